// File: doc/BRIEF.md
# Flash configuration write-protection controller

This block keeps the boot-status byte of a flash-based controller together with two other configuration bytes (a user configuration byte and a boot-vector byte). It decides whether the flash array may be written and whether any configuration byte may be written. It also forms the address where execution starts after reset. Software or a programmer talks to it through a command register and a data register. A two-bit mode input tells it which programming path is active: in-system, in-application, in-circuit or parallel programmer.

Once the configuration protect flag is set, only one thing can lift it: a clear-protection command on the command register, followed by the key value 0x96 on the data register. A sticky disable flag can block that sequence on the two software-driven paths. Only the two external programming paths can clear the disable flag itself.

Top module: `cfgprot_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x01, flash_we is 1, all three cfg_allow bits are 1, and start_addr is the reset boot vector (default 0x1F) followed by 0x00, giving 0x1F00.
- R2: The status bit at position 0 is the boot select. When it is 1, start_addr is {boot vector, 8'h00}. When it is 0, start_addr is 0.
- R3: When the status bit at position 5 (write-protect arming) is 0, flash_we is 1, whatever commands arrive.
- R4: When status bit 5 is 1, command 0x3C sets flash_we and command 0x5A clears it. Each change is visible from the clock edge that takes the command.
- R5: When the status bit at position 6 (configuration protect) is 1, cfg_allow is 0. A configuration write then leaves its byte unchanged and raises cfg_err for exactly one cycle after the write edge. When bit 6 is 0, the write is stored at that edge. cfg_sel encodes 0 = user config, 1 = boot vector, 2 = status, 3 = no byte.
- R6: Command 0x67 on the command register, followed by a data-register write of 0x96, clears status bit 6 at the edge of the data write.
- R7: When the status bit at position 7 (clear disable) is 1, the clear sequence has no effect in modes 0 (in-system) and 1 (in-application). In modes 2 (in-circuit) and 3 (parallel) the sequence clears both bit 7 and bit 6.
- R8: Writing the status byte loads bits 6, 5 and 0 from the data. Bit 7 can be set this way but is never cleared by a status write.
- R9: If the next data-register write after command 0x67 is not 0x96, or another command comes first, the sequence is abandoned. A later lone 0x96 does nothing.
- R10: Data written to status bits 4 to 1 is dropped, and these bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_val | input | 8 | Command code |
| data_wr | input | 1 | Write strobe for the data register |
| data_val | input | 8 | Data register value |
| prog_mode | input | 2 | 0 in-system, 1 in-application, 2 in-circuit, 3 parallel |
| cfg_wr | input | 1 | Configuration byte write request |
| cfg_sel | input | 2 | Target byte (0 user, 1 boot vector, 2 status) |
| cfg_wdata | input | 8 | Byte to write |
| flash_we | output | 1 | Effective flash write enable |
| cfg_allow | output | 3 | Per-byte write permission, index as cfg_sel |
| cfg_err | output | 1 | One-cycle strobe for a blocked write |
| start_addr | output | 16 | Reset start address |
| status | output | 8 | Boot-status byte |
| bootvec | output | 8 | Boot-vector byte |
| usercfg | output | 8 | User configuration byte |

## Verification
The properties assume that at most one of cmd_wr, data_wr and cfg_wr is high in any cycle. They also assume that prog_mode only changes when no register write is in progress. The tasks drive each strobe for a single cycle, one at a time, and change prog_mode only between complete sequences. So the order in which the sequencer and the byte store see events is always clear. The sticky-flag properties take it that the clear pulses are the only path that may lower the protect flags, and the stimulus tries status writes as a second path to show that it is closed.

// File: rtl/cfgprot_pkg.sv
package cfgprot_pkg;
    localparam int BYTE_W   = 8;
    localparam int SEL_W    = 2;
    localparam int NUM_CFG  = 3;

    localparam logic [BYTE_W-1:0] CMD_SET_WE  = 8'h3C;
    localparam logic [BYTE_W-1:0] CMD_CLR_WE  = 8'h5A;
    localparam logic [BYTE_W-1:0] CMD_UNLOCK  = 8'h67;
    localparam logic [BYTE_W-1:0] UNLOCK_KEY  = 8'h96;

    localparam logic [SEL_W-1:0] SEL_USER = 2'd0;
    localparam logic [SEL_W-1:0] SEL_VEC  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;

    typedef enum logic [1:0] {
        MODE_INSYS  = 2'd0,
        MODE_INAPP  = 2'd1,
        MODE_INCIRC = 2'd2,
        MODE_PARPRG = 2'd3
    } prog_mode_e;

    typedef struct packed {
        logic armed;
        logic we;
    } seq_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ucfg;
        logic [BYTE_W-1:0] bvec;
        logic              lockdis;
        logic              lock;
        logic              arm_wp;
        logic              bsel;
        logic              err;
    } store_state_t;
endpackage

// File: rtl/cfgprot_seq.sv
module cfgprot_seq
    import cfgprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] cmd_val,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_val,
    input  logic [1:0]        prog_mode,
    input  logic              lockdis,
    input  logic              arm_wp,
    output logic              clr_lock,
    output logic              clr_lockdis,
    output logic              flash_we
);
    seq_state_t st_d, st_q;
    logic ext_path;
    logic key_hit;

    always_comb begin
        st_d        = st_q;
        clr_lock    = 1'b0;
        clr_lockdis = 1'b0;
        ext_path    = (prog_mode == MODE_INCIRC) || (prog_mode == MODE_PARPRG);
        key_hit     = data_wr && st_q.armed && (data_val == UNLOCK_KEY);

        if (key_hit && (ext_path || !lockdis)) begin
            clr_lock    = 1'b1;
            clr_lockdis = ext_path;
        end
        if (data_wr) st_d.armed = 1'b0;
        if (cmd_wr)  st_d.armed = (cmd_val == CMD_UNLOCK);

        if (!arm_wp)
            st_d.we = 1'b1;
        else if (cmd_wr && cmd_val == CMD_SET_WE)
            st_d.we = 1'b1;
        else if (cmd_wr && cmd_val == CMD_CLR_WE)
            st_d.we = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b0, we: 1'b1};
        else        st_q <= st_d;
    end

    assign flash_we = st_q.we | ~arm_wp;

    p_we_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_wp |=> st_q.we);
    p_we_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wp && !cmd_wr) |=> $stable(st_q.we));
    p_ext_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lockdis |-> prog_mode[1]);
endmodule

// File: rtl/cfgprot_store.sv
module cfgprot_store
    import cfgprot_pkg::*;
#(
    parameter logic [BYTE_W-1:0] UCFG_RST = 8'h00,
    parameter logic [BYTE_W-1:0] BVEC_RST = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              clr_lock,
    input  logic              clr_lockdis,
    output logic [NUM_CFG-1:0] cfg_allow,
    output logic              cfg_err,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] bootvec,
    output logic [BYTE_W-1:0] usercfg,
    output logic              lockdis,
    output logic              arm_wp,
    output logic              bsel
);
    store_state_t sd, sq;
    logic [NUM_CFG-1:0] hit;

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_byte
        assign hit[i]       = cfg_wr && (cfg_sel == SEL_W'(i));
        assign cfg_allow[i] = ~sq.lock;
    end

    always_comb begin
        sd     = sq;
        sd.err = 1'b0;
        if (|hit) begin
            if (sq.lock) begin
                sd.err = 1'b1;
            end else begin
                if (hit[SEL_USER]) sd.ucfg = cfg_wdata;
                if (hit[SEL_VEC])  sd.bvec = cfg_wdata;
                if (hit[SEL_STAT]) begin
                    sd.lockdis = sq.lockdis | cfg_wdata[7];
                    sd.lock    = cfg_wdata[6];
                    sd.arm_wp  = cfg_wdata[5];
                    sd.bsel    = cfg_wdata[0];
                end
            end
        end
        if (clr_lock)    sd.lock    = 1'b0;
        if (clr_lockdis) sd.lockdis = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sq <= '{ucfg: UCFG_RST, bvec: BVEC_RST, lockdis: 1'b0, lock: 1'b0,
                    arm_wp: 1'b0, bsel: 1'b1, err: 1'b0};
        else
            sq <= sd;
    end

    assign status  = {sq.lockdis, sq.lock, sq.arm_wp, 4'b0000, sq.bsel};
    assign bootvec = sq.bvec;
    assign usercfg = sq.ucfg;
    assign cfg_err = sq.err;
    assign lockdis = sq.lockdis;
    assign arm_wp  = sq.arm_wp;
    assign bsel    = sq.bsel;

    p_block_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel != 2'd3 && sq.lock) |=> cfg_err);
    p_block_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_VEC && sq.lock) |=> $stable(bootvec));
    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sq.lock && !clr_lock) |=> sq.lock);
    p_lockdis_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sq.lockdis && !clr_lockdis) |=> sq.lockdis);
endmodule

// File: rtl/cfgprot_ctrl.sv
module cfgprot_ctrl
    import cfgprot_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [BYTE_W-1:0] UCFG_RST = 8'h00,
    parameter logic [BYTE_W-1:0] BVEC_RST = 8'h1F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [7:0]         cmd_val,
    input  logic               data_wr,
    input  logic [7:0]         data_val,
    input  logic [1:0]         prog_mode,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_sel,
    input  logic [7:0]         cfg_wdata,
    output logic               flash_we,
    output logic [2:0]         cfg_allow,
    output logic               cfg_err,
    output logic [ADDR_W-1:0]  start_addr,
    output logic [7:0]         status,
    output logic [7:0]         bootvec,
    output logic [7:0]         usercfg
);
    localparam int LOW_W = ADDR_W - BYTE_W;

    logic clr_lock, clr_lockdis, lockdis, arm_wp, bsel;

    cfgprot_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_val(cmd_val),
        .data_wr(data_wr), .data_val(data_val),
        .prog_mode(prog_mode), .lockdis(lockdis), .arm_wp(arm_wp),
        .clr_lock(clr_lock), .clr_lockdis(clr_lockdis), .flash_we(flash_we)
    );

    cfgprot_store #(.UCFG_RST(UCFG_RST), .BVEC_RST(BVEC_RST)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .clr_lock(clr_lock), .clr_lockdis(clr_lockdis),
        .cfg_allow(cfg_allow), .cfg_err(cfg_err),
        .status(status), .bootvec(bootvec), .usercfg(usercfg),
        .lockdis(lockdis), .arm_wp(arm_wp), .bsel(bsel)
    );

    assign start_addr = bsel ? {bootvec, {LOW_W{1'b0}}} : '0;

    p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status[0] |-> (start_addr == '0));
endmodule

// File: tb/cfgprot_ctrl_test.sv
module cfgprot_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 0, data_wr = 0, cfg_wr = 0;
    logic [7:0] cmd_val = 0, data_val = 0, cfg_wdata = 0;
    logic [1:0] prog_mode = 0, cfg_sel = 0;
    logic flash_we, cfg_err;
    logic [2:0] cfg_allow;
    logic [15:0] start_addr;
    logic [7:0] status, bootvec, usercfg;
    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    cfgprot_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
        .data_wr(data_wr), .data_val(data_val), .prog_mode(prog_mode),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .flash_we(flash_we), .cfg_allow(cfg_allow), .cfg_err(cfg_err),
        .start_addr(start_addr), .status(status), .bootvec(bootvec),
        .usercfg(usercfg)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_cmd(logic [7:0] v);
        cmd_val = v; cmd_wr = 1; @(negedge clk); cmd_wr = 0;
    endtask
    task automatic do_data(logic [7:0] v);
        data_val = v; data_wr = 1; @(negedge clk); data_wr = 0;
    endtask
    task automatic do_cfg(logic [1:0] s, logic [7:0] v);
        cfg_sel = s; cfg_wdata = v; cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    endtask
    task automatic unlock();
        do_cmd(8'h67); do_data(8'h96);
    endtask

    task automatic t_reset();
        chk("R1 status", status, 8'h01);
        chk("R1 flash_we", flash_we, 1);
        chk("R1 allow", cfg_allow, 3'b111);
        chk("R1 start", start_addr, 16'h1F00);
    endtask

    task automatic t_start();
        do_cfg(2'd1, 8'h42);
        chk("R2 start vec", start_addr, 16'h4200);
        do_cfg(2'd2, 8'h00);
        chk("R2 start zero", start_addr, 16'h0000);
        do_cfg(2'd2, 8'h01);
        chk("R2 start back", start_addr, 16'h4200);
    endtask

    task automatic t_reserved();
        do_cfg(2'd2, 8'h1F);
        chk("R10 reserved", status, 8'h01);
    endtask

    task automatic t_we();
        do_cmd(8'h5A);
        chk("R3 forced", flash_we, 1);
        do_cfg(2'd2, 8'h21);
        chk("R4 armed keeps", flash_we, 1);
        do_cmd(8'h5A);
        chk("R4 clear", flash_we, 0);
        do_cmd(8'h3C);
        chk("R4 set", flash_we, 1);
        do_cmd(8'h5A);
        do_cfg(2'd2, 8'h01);
        chk("R3 disarm", flash_we, 1);
    endtask

    task automatic t_protect();
        do_cfg(2'd0, 8'hA5);
        chk("R5 open write", usercfg, 8'hA5);
        do_cfg(2'd2, 8'h41);
        chk("R5 allow off", cfg_allow, 3'b000);
        do_cfg(2'd1, 8'h77);
        chk("R5 err", cfg_err, 1);
        chk("R5 vec kept", bootvec, 8'h42);
        @(negedge clk);
        chk("R5 err one cycle", cfg_err, 0);
        do_cfg(2'd0, 8'h3C);
        chk("R5 user kept", usercfg, 8'hA5);
        do_cfg(2'd2, 8'h01);
        chk("R5 status kept", status, 8'h41);
    endtask

    task automatic t_clear();
        unlock();
        chk("R6 cleared", status, 8'h01);
        chk("R6 allow", cfg_allow, 3'b111);
        do_cfg(2'd1, 8'h55);
        chk("R6 write after", bootvec, 8'h55);
    endtask

    task automatic t_abort();
        do_cfg(2'd2, 8'h41);
        do_cmd(8'h67); do_data(8'h12); do_data(8'h96);
        chk("R9 wrong key", status, 8'h41);
        do_cmd(8'h67); do_cmd(8'h3C); do_data(8'h96);
        chk("R9 other cmd", status, 8'h41);
        unlock();
        chk("R9 recover", status, 8'h01);
    endtask

    task automatic t_lockdis();
        prog_mode = 2'd0;
        do_cfg(2'd2, 8'hC1);
        chk("R8 set dis", status, 8'hC1);
        unlock();
        chk("R7 insys blocked", status, 8'hC1);
        prog_mode = 2'd1; @(negedge clk);
        unlock();
        chk("R7 inapp blocked", status, 8'hC1);
        prog_mode = 2'd2; @(negedge clk);
        unlock();
        chk("R7 incirc clears", status, 8'h01);
        prog_mode = 2'd0; @(negedge clk);
        do_cfg(2'd2, 8'h81);
        do_cfg(2'd2, 8'h01);
        chk("R8 not cleared by write", status, 8'h81);
        do_cfg(2'd2, 8'hC1);
        prog_mode = 2'd3; @(negedge clk);
        unlock();
        chk("R7 parallel clears", status, 8'h01);
        prog_mode = 2'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_reserved();
        t_we();
        t_protect();
        t_clear();
        t_abort();
        t_lockdis();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule